// File: doc/BRIEF.md
# Masked-address GPIO controller

An eight-pin general-purpose I/O controller sitting on a simple memory-mapped register bus. Each pin can be an input or an output. A per-pin flag selects an alternate function, which a neighbouring multiplexer consumes. The data register is reached through a 256-word address window. The word address itself acts as a per-pin mask, so software can read or modify any subset of pins in one access, without a read-modify-write sequence.

Every pin can also be an interrupt source. Three settings per pin choose edge or level sensing, one or both edges, and active polarity. Inputs cross a two-flop synchronizer before detection. Edge events are latched until software writes ones to a clear register; level events follow the synchronized pin. The enabled status is exported as an eight-bit vector plus one combined interrupt line.

Top module: `mgpio_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_out`, `pin_oe`, `alt_sel`, `irq_vec`, `irq` and `bus_rdata` are 0, and every read/write register reads back 0.
- R2: A write to any word address below 0x400 updates `pin_out` bit n to the write-data bit n only if address bit n+2 is 1 and direction bit n is 1; every other output bit keeps its value.
- R3: A read below 0x400 returns 0 in bit n when address bit n+2 is 0; otherwise it returns the stored output bit for an output pin, or the synchronized `pin_in` bit for an input pin.
- R4: The direction register at 0x400 (1 = output) drives `pin_oe`. The alternate-function register at 0x420 drives `alt_sel`. Both read back what was written.
- R5: A pin whose sense bit (register 0x404) is 0 is edge-sensed. Polarity bit 1 (register 0x40C) selects rising edges and 0 selects falling edges. A detected edge sets the pin's raw status bit (read at 0x414). The bit stays set until a 1 is written to that bit of the clear register at 0x41C.
- R6: For an edge-sensed pin, a 1 in the both-edges register at 0x408 latches either edge, whatever the polarity bit says.
- R7: For a pin with sense bit 1, the raw status equals (synchronized level == polarity bit). Writing the clear register has no effect on it.
- R8: The masked status (read at 0x418) is raw AND the enable register at 0x410. `irq_vec` shows the masked status one cycle after the raw status. `irq` is high exactly when that vector is nonzero.
- R9: When an edge is detected in the same cycle as a clear write to that pin, the raw status bit ends up set.
- R10: A read of address 0xFE0 + 4k (k = 0..7) returns the byte k of the sequence 0x3A, 0x17, 0x05, 0x00, 0xC1, 0x9E, 0x42, 0x6D. `bus_rdata` changes only on a clock edge where `bus_sel` is 1 and `bus_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output values |
| pin_oe | output | 8 | Output enables (1 = drive) |
| alt_sel | output | 8 | Alternate-function select per pin |
| irq | output | 1 | Combined interrupt |
| irq_vec | output | 8 | Masked interrupt status |

## Verification
The data window is swept over all 256 address masks. This is done under four direction patterns for writes and two direction/input combinations for reads. The sweep separates the address-mask term from the direction term and exposes any bit-position slip.

Interrupt detection is tried with sixteen arithmetically generated sequences of pin pattern, polarity, both-edges and enable values. These separate rising from falling detection and the both-edges override from the polarity bit. A level sweep confirms that clears cannot remove an active level. A cycle-aligned clear collides with a fresh edge to show which one wins.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  localparam logic [11:0] OFS_DIR   = 12'h400;
  localparam logic [11:0] OFS_SENSE = 12'h404;
  localparam logic [11:0] OFS_BOTH  = 12'h408;
  localparam logic [11:0] OFS_POL   = 12'h40C;
  localparam logic [11:0] OFS_IE    = 12'h410;
  localparam logic [11:0] OFS_RAW   = 12'h414;
  localparam logic [11:0] OFS_MSK   = 12'h418;
  localparam logic [11:0] OFS_CLR   = 12'h41C;
  localparam logic [11:0] OFS_ALT   = 12'h420;
  localparam logic [11:0] OFS_ID0   = 12'hFE0;

  typedef enum logic [3:0] {
    RS_NONE, RS_DATA, RS_DIR, RS_SENSE, RS_BOTH, RS_POL,
    RS_IE, RS_RAW, RS_MSK, RS_CLR, RS_ALT, RS_ID
  } regsel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h3A;
      3'd1: id_byte = 8'h17;
      3'd2: id_byte = 8'h05;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'hC1;
      3'd5: id_byte = 8'h9E;
      3'd6: id_byte = 8'h42;
      default: id_byte = 8'h6D;
    endcase
  endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mgpio_detect.sv
module mgpio_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] edge_evt,
  output logic [W-1:0] raw
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic prev_q;
    logic raw_q;
    logic rise, fall, hit, match;

    always_comb begin
      rise  = lvl[i] & ~prev_q;
      fall  = ~lvl[i] & prev_q;
      hit   = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
      match = pol[i] ? lvl[i] : ~lvl[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        raw_q  <= 1'b0;
      end else begin
        prev_q <= lvl[i];
        if (sense[i]) raw_q <= match;
        else          raw_q <= (raw_q & ~clr[i]) | hit;
      end
    end

    assign edge_evt[i] = hit;
    assign raw[i]      = raw_q;
  end
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  pin_lvl,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  sense_q,
  output logic [W-1:0]  both_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  ie_q,
  output logic [W-1:0]  alt_q,
  output logic [W-1:0]  clr_pulse,
  output logic [W-1:0]  rdata_q
);
  localparam int MHI = W + 1;

  regsel_e      sel;
  logic [W-1:0] amask;
  logic [W-1:0] rd_mux;
  logic         wr_en;
  logic [W-1:0] wmask;

  assign amask = bus_addr[MHI:2];
  assign wr_en = bus_sel & bus_wr;
  assign wmask = amask & dir_q;

  always_comb begin
    sel = RS_NONE;
    if (bus_addr[AW-1:MHI+1] == '0)                            sel = RS_DATA;
    else if (bus_addr == AW'(OFS_DIR))                          sel = RS_DIR;
    else if (bus_addr == AW'(OFS_SENSE))                        sel = RS_SENSE;
    else if (bus_addr == AW'(OFS_BOTH))                         sel = RS_BOTH;
    else if (bus_addr == AW'(OFS_POL))                          sel = RS_POL;
    else if (bus_addr == AW'(OFS_IE))                           sel = RS_IE;
    else if (bus_addr == AW'(OFS_RAW))                          sel = RS_RAW;
    else if (bus_addr == AW'(OFS_MSK))                          sel = RS_MSK;
    else if (bus_addr == AW'(OFS_CLR))                          sel = RS_CLR;
    else if (bus_addr == AW'(OFS_ALT))                          sel = RS_ALT;
    else if (bus_addr >= AW'(OFS_ID0) && bus_addr[1:0] == 2'b00) sel = RS_ID;
  end

  assign clr_pulse = (wr_en && sel == RS_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      alt_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        RS_DATA:  dout_q  <= (dout_q & ~wmask) | (bus_wdata & wmask);
        RS_DIR:   dir_q   <= bus_wdata;
        RS_SENSE: sense_q <= bus_wdata;
        RS_BOTH:  both_q  <= bus_wdata;
        RS_POL:   pol_q   <= bus_wdata;
        RS_IE:    ie_q    <= bus_wdata;
        RS_ALT:   alt_q   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RS_DATA:  rd_mux = amask & ((dir_q & dout_q) | (~dir_q & pin_lvl));
      RS_DIR:   rd_mux = dir_q;
      RS_SENSE: rd_mux = sense_q;
      RS_BOTH:  rd_mux = both_q;
      RS_POL:   rd_mux = pol_q;
      RS_IE:    rd_mux = ie_q;
      RS_RAW:   rd_mux = raw;
      RS_MSK:   rd_mux = raw & ie_q;
      RS_ALT:   rd_mux = alt_q;
      RS_ID:    rd_mux = W'(id_byte(bus_addr[4:2]));
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/mgpio_top.sv
module mgpio_top #(
  parameter int NPIN        = 8,
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] alt_sel,
  output logic            irq,
  output logic [NPIN-1:0] irq_vec
);
  logic [NPIN-1:0] lvl_w, raw_w, edge_w, clr_w;
  logic [NPIN-1:0] sense_w, both_w, pol_w, ie_w;
  logic [NPIN-1:0] mis_q;
  logic            irq_q;

  mgpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_w)
  );

  mgpio_regs #(.W(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pin_lvl(lvl_w), .raw(raw_w),
    .dout_q(pin_out), .dir_q(pin_oe), .sense_q(sense_w), .both_q(both_w),
    .pol_q(pol_w), .ie_q(ie_w), .alt_q(alt_sel), .clr_pulse(clr_w),
    .rdata_q(bus_rdata)
  );

  mgpio_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst(rst), .lvl(lvl_w), .sense(sense_w), .both(both_w),
    .pol(pol_w), .clr(clr_w), .edge_evt(edge_w), .raw(raw_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_q <= '0;
      irq_q <= 1'b0;
    end else begin
      mis_q <= raw_w & ie_w;
      irq_q <= |(raw_w & ie_w);
    end
  end

  assign irq_vec = mis_q;
  assign irq     = irq_q;
endmodule

// File: rtl/mgpio_chk.sv
module mgpio_chk
  import mgpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic [W-1:0]  irq_vec,
  input logic [W-1:0]  lvl,
  input logic [W-1:0]  raw,
  input logic [W-1:0]  edge_evt,
  input logic [W-1:0]  sense,
  input logic [W-1:0]  pol,
  input logic [W-1:0]  ie
);
  logic [W-1:0] active_lvl;
  assign active_lvl = sense & ~(lvl ^ pol);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !irq && irq_vec == '0));

  // R2
  input_pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  // R7
  level_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(active_lvl) & ~raw) == '0);

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_vec & ~$past(ie)) == '0);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(raw & ie) != '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(edge_evt & ~sense) & ~raw) == '0);

  // R10
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == AW'(OFS_ID0)) |=> bus_rdata == W'(id_byte(3'd0)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind mgpio_top mgpio_chk #(.W(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .irq_vec(irq_vec), .lvl(lvl_w), .raw(raw_w), .edge_evt(edge_w),
  .sense(sense_w), .pol(pol_w), .ie(ie_w)
);

// File: tb/tb_mgpio_top.sv
`timescale 1ns/1ps
module tb_mgpio_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe, alt_sel, irq_vec;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mgpio_top dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] edge_exp(input logic [7:0] o, input logic [7:0] n,
                                          input logic [7:0] pol, input logic [7:0] both);
    logic [7:0] rise, fall;
    rise = n & ~o;
    fall = o & ~n;
    return (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
  endfunction

  initial begin
    logic [7:0] v, model, dirv, cur, polv, bothv, iev, nxt;
    logic [7:0] ids [8];
    ids = '{8'h3A, 8'h17, 8'h05, 8'h00, 8'hC1, 8'h9E, 8'h42, 8'h6D};
    repeat (4) @(negedge clk);
    // R1 outputs during reset
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 irq_vec", irq_vec, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    rd(12'h400, v); chk("R1 dir readback", v, 8'h00);
    rd(12'h414, v); chk("R1 raw readback", v, 8'h00);
    rd(12'h420, v); chk("R1 alt readback", v, 8'h00);

    // R4 direction and alternate select
    wr(12'h420, 8'hB6); chk("R4 alt_sel", alt_sel, 8'hB6);
    rd(12'h420, v);     chk("R4 alt readback", v, 8'hB6);

    // R2 write sweep over all masks for several direction patterns
    model = '0;
    for (int d = 0; d < 4; d++) begin
      dirv = (d == 0) ? 8'h00 : (d == 1) ? 8'hA5 : (d == 2) ? 8'hFF : 8'h3C;
      wr(12'h400, dirv);
      chk("R4 pin_oe", pin_oe, dirv);
      for (int m = 0; m < 256; m++) begin
        v = 8'(m * 37) ^ 8'h5A ^ 8'(d * 71);
        wr(12'(m << 2), v);
        model = (model & ~(8'(m) & dirv)) | (v & 8'(m) & dirv);
        chk("R2 masked write", pin_out, model);
      end
    end

    // R3 read sweep
    pin_in = 8'h6C;
    for (int d = 0; d < 2; d++) begin
      dirv = d ? 8'h0F : 8'hC3;
      wr(12'h400, dirv);
      settle();
      for (int m = 0; m < 256; m++) begin
        rd(12'(m << 2), v);
        chk("R3 masked read", v, 8'(m) & ((dirv & model) | (~dirv & pin_in)));
      end
    end
    wr(12'h400, 8'h00);

    // R10 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(k * 4), v);
      chk("R10 id byte", v, ids[k]);
    end
    // R10 read data holds across non-read cycles
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", bus_rdata, ids[7]);

    // R5 R6 R8 edge sweep
    wr(12'h404, 8'h00);
    cur = pin_in;
    for (int k = 0; k < 16; k++) begin
      polv  = 8'(k * 29) ^ 8'h96;
      bothv = (k < 4) ? 8'h00 : 8'(k * 11);
      iev   = 8'(k * 53) | 8'h01;
      nxt   = 8'(k * 75) ^ 8'hC3 ^ cur;
      wr(12'h40C, polv);
      wr(12'h408, bothv);
      wr(12'h410, iev);
      wr(12'h41C, 8'hFF);
      rd(12'h414, v); chk("R5 cleared", v, 8'h00);
      pin_in = nxt;
      settle();
      rd(12'h414, v);
      chk((k < 4) ? "R5 edge latch" : "R6 both edges", v, edge_exp(cur, nxt, polv, bothv));
      rd(12'h418, v);
      chk("R8 masked status", v, edge_exp(cur, nxt, polv, bothv) & iev);
      chk("R8 irq_vec", irq_vec, edge_exp(cur, nxt, polv, bothv) & iev);
      chk("R8 irq", {7'd0, irq}, {7'd0, (edge_exp(cur, nxt, polv, bothv) & iev) != 8'h00});
      // R5 latched after partial clear, pins unchanged
      wr(12'h41C, 8'h0F);
      rd(12'h414, v);
      chk("R5 partial clear", v, edge_exp(cur, nxt, polv, bothv) & 8'hF0);
      cur = nxt;
    end

    // R9 edge colliding with clear
    wr(12'h408, 8'hFF);
    wr(12'h41C, 8'hFF);
    pin_in = cur ^ 8'h01;
    settle();
    rd(12'h414, v); chk("R6 toggle set", v, 8'h01);
    pin_in = pin_in ^ 8'h01;
    @(negedge clk);
    @(negedge clk);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R9 edge beats clear", v, 8'h01);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R5 clear without edge", v, 8'h00);
    cur = pin_in;

    // R7 level sweep
    wr(12'h404, 8'hFF);
    wr(12'h410, 8'hFF);
    for (int k = 0; k < 12; k++) begin
      polv = 8'(k * 43) ^ 8'h0F;
      nxt  = 8'(k * 91) ^ 8'h33;
      wr(12'h40C, polv);
      pin_in = nxt;
      settle();
      rd(12'h414, v);
      chk("R7 level raw", v, (polv & nxt) | (~polv & ~nxt));
      wr(12'h41C, 8'hFF);
      rd(12'h414, v);
      chk("R7 clear ignored", v, (polv & nxt) | (~polv & ~nxt));
      chk("R8 level irq_vec", irq_vec, (polv & nxt) | (~polv & ~nxt));
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule